// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the per-interrupt bookkeeping of a small multi-processor interrupt distributor. It watches a flat vector of interrupt input wires and folds them onto interrupt IDs. Some wires are shared lines that reach every processor. The others are private lines, a bank of 32 for each processor. For every ID and processor the block holds the last seen wire level and a latched pending flag. For every ID it holds an enable bit and a trigger-mode bit.

Software-style access uses one write strobe that carries an operation code, a 32-bit word index, a processor select and 32 data bits, plus a read strobe with a word index. A wire that is high on a level-sensitive interrupt is reported as pending whatever the latched flag says. Clearing pending therefore only removes the latched part, and an edge-sensitive line latches pending even while its interrupt is disabled.

Top module: `irqPendTracker`

## Requirements
- R1: Input index k with k < NUM_SHARED (32) drives interrupt ID k+32 and targets all processors.
- R2: Input index NUM_SHARED + 32*c + j drives interrupt ID j for processor c only.
- R3: When a wire goes from low to high, the stored level is set and the latched pending flag is set on its target processors if the ID is edge-triggered (even when disabled) or enabled.
- R4: An ID whose trigger bit is 0 (level mode) reports pending while its wire is high, even when it is disabled and its latched flag is clear.
- R5: A high-to-low wire change clears only the stored level; it never clears a latched pending flag.
- R6: When the wire level equals the stored level and no pending write occurs, the latched pending state does not change.
- R7: A write with op 3 (set-pending) sets the latched flag for each ID whose data bit is 1 in the addressed word (ID = 32*word + bit); for IDs 32 and up on all processors, for IDs below 32 only on the processor given by the processor select. Zero bits have no effect.
- R8: A write with op 4 (clear-pending) clears only the latched flag of the ID bits written with 1, targeted as in R7; a level-mode ID whose wire is still high stays pending.
- R9: Op 1 sets and op 2 clears enable bits for IDs written with 1. Op 5 loads the whole word of trigger bits (1 = edge, 0 = level). Op 0 and codes 6 and 7 change nothing.
- R10: A read request returns, one cycle later, 32 bits of the addressed word, each bit the OR over processors of latched flag OR (level-mode AND stored level). The result holds when no read is requested.
- R11: A synchronous active-low reset clears all levels, latched flags, enables and the read result, and puts every ID in level mode.
- R12: When a rising wire and a clear-pending write hit the same ID and processor in one cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| irqLines | input | NUM_IN (160) | Interrupt wires: shared lines first, then 32 per processor |
| wrEn | input | 1 | Write strobe |
| wrOp | input | 3 | Write operation code |
| wrWord | input | WORD_W (1) | Word index of the write |
| wrCpu | input | CPU_W (2) | Processor select for private IDs |
| wrData | input | 32 | One bit per ID in the word |
| rdEn | input | 1 | Read strobe |
| rdWord | input | WORD_W (1) | Word index of the read |
| rdData | output | 32 | Pending readback, valid one cycle after rdEn |

## Verification
The assertions take for granted that the wires are already synchronous to clk and that only one write operation arrives per cycle. The port shape guarantees the second point. The assertions also assume word indices stay inside the ID range. The stimulus drives wires and strobes one time unit after the rising edge. It draws word indices only from the existing words and op codes only from 0 to 5. Random wire toggles, trigger loads and pending writes are then mixed freely, including same-cycle conflicts.

// File: rtl/irqPendPkg.sv
package irqPendPkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_EN   = 3'd1,
    OP_CLR_EN   = 3'd2,
    OP_SET_PEND = 3'd3,
    OP_CLR_PEND = 3'd4,
    OP_TRIG     = 3'd5
  } wrOpT;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setPend;
    logic clrPend;
    logic trigWr;
    logic rdReq;
  } ctrlStrobeT;
endpackage

// File: rtl/irqLineMap.sv
// Folds the flat wire vector onto (ID, processor) cells: cell = id*NUM_CPU + cpu.
module irqLineMap #(
  parameter int NUM_CPU    = 4,
  parameter int NUM_SHARED = 32,
  parameter int PRIV       = 32,
  localparam int NUM_ID    = PRIV + NUM_SHARED,
  localparam int NUM_IN    = NUM_SHARED + NUM_CPU * PRIV,
  localparam int NUM_CELL  = NUM_ID * NUM_CPU
) (
  input  logic [NUM_IN-1:0]   irqLines,
  output logic [NUM_CELL-1:0] cellIn
);
  for (genvar id = 0; id < NUM_ID; id++) begin : g_id
    for (genvar cpu = 0; cpu < NUM_CPU; cpu++) begin : g_cpu
      if (id < PRIV) begin : g_priv
        assign cellIn[id*NUM_CPU+cpu] = irqLines[NUM_SHARED + cpu*PRIV + id]; // R2
      end else begin : g_shared
        assign cellIn[id*NUM_CPU+cpu] = irqLines[id - PRIV];                  // R1
      end
    end
  end
endmodule

// File: rtl/irqPendCtrl.sv
module irqPendCtrl
  import irqPendPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrOp,
  input  logic       rdEn,
  output ctrlStrobeT strobes
);
  wrOpT opDec;

  always_comb begin
    opDec   = wrOpT'(wrOp);
    strobes = '0;
    strobes.rdReq = rdEn;
    if (wrEn) begin
      case (opDec)
        OP_SET_EN:   strobes.setEn   = 1'b1;
        OP_CLR_EN:   strobes.clrEn   = 1'b1;
        OP_SET_PEND: strobes.setPend = 1'b1;
        OP_CLR_PEND: strobes.clrPend = 1'b1;
        OP_TRIG:     strobes.trigWr  = 1'b1;
        default:     ;
      endcase
    end
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setEn, strobes.clrEn, strobes.setPend, strobes.clrPend, strobes.trigWr})); // R9
endmodule

// File: rtl/irqPendDatapath.sv
module irqPendDatapath
  import irqPendPkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_SHARED = 32,
  parameter int PRIV       = 32,
  localparam int NUM_ID    = PRIV + NUM_SHARED,
  localparam int NUM_CELL  = NUM_ID * NUM_CPU,
  localparam int ID_WORDS  = NUM_ID / PRIV,
  localparam int WORD_W    = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CELL-1:0] cellIn,
  input  ctrlStrobeT          strobes,
  input  logic [WORD_W-1:0]   wrWord,
  input  logic [CPU_W-1:0]    wrCpu,
  input  logic [PRIV-1:0]     wrData,
  input  logic [WORD_W-1:0]   rdWord,
  output logic [PRIV-1:0]     rdData
);
  logic [NUM_CELL-1:0] levelQ, latchQ, latchD, setHit, clrHit, riseSet, effPend, edgeCell, edgeRise;
  logic [NUM_ID-1:0]   enQ, enD, trigQ, trigD, idPend;
  logic [PRIV-1:0]     rdSel;

  for (genvar id = 0; id < NUM_ID; id++) begin : g_id
    localparam int WORD = id / PRIV;
    localparam int BITP = id % PRIV;
    logic hitBit, wordSel;
    assign wordSel = (wrWord == WORD_W'(WORD));
    assign hitBit  = wrData[BITP] && wordSel;

    always_comb begin
      enD[id] = enQ[id];
      if (strobes.setEn && hitBit)      enD[id] = 1'b1;
      else if (strobes.clrEn && hitBit) enD[id] = 1'b0;
      trigD[id] = (strobes.trigWr && wordSel) ? wrData[BITP] : trigQ[id];
    end

    for (genvar cpu = 0; cpu < NUM_CPU; cpu++) begin : g_cpu
      localparam int CELL = id * NUM_CPU + cpu;
      logic cpuHit;
      if (id >= PRIV) begin : g_all
        assign cpuHit = 1'b1;
      end else begin : g_one
        assign cpuHit = (wrCpu == CPU_W'(cpu));
      end
      assign setHit[CELL]   = strobes.setPend && hitBit && cpuHit;
      assign clrHit[CELL]   = strobes.clrPend && hitBit && cpuHit;
      assign edgeCell[CELL] = trigQ[id];
      assign riseSet[CELL]  = cellIn[CELL] && !levelQ[CELL] && (trigQ[id] || enQ[id]);
      assign latchD[CELL]   = (latchQ[CELL] && !clrHit[CELL]) || setHit[CELL] || riseSet[CELL];
      assign effPend[CELL]  = latchQ[CELL] || (levelQ[CELL] && !trigQ[id]);
    end

    assign idPend[id] = |effPend[id*NUM_CPU +: NUM_CPU];
  end

  assign edgeRise = cellIn & ~levelQ & edgeCell;

  always_comb begin
    rdSel = '0;
    for (int w = 0; w < ID_WORDS; w++) begin
      if (rdWord == WORD_W'(w)) rdSel = idPend[w*PRIV +: PRIV];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      latchQ <= '0;
      enQ    <= '0;
      trigQ  <= '0;
      rdData <= '0;
    end else begin
      levelQ <= cellIn;
      latchQ <= latchD;
      enQ    <= enD;
      trigQ  <= trigD;
      if (strobes.rdReq) rdData <= rdSel;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (levelQ == '0 && latchQ == '0 && enQ == '0 && trigQ == '0)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.setPend && !strobes.clrPend && cellIn == levelQ) |=> $stable(latchQ)); // R6

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clrPend |=> ((latchQ & $past(latchQ)) == $past(latchQ))); // R5

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeRise) |=> ((latchQ & $past(edgeRise)) == $past(edgeRise))); // R3
endmodule

// File: rtl/irqPendTracker.sv
module irqPendTracker
  import irqPendPkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int NUM_SHARED = 32,
  localparam int PRIV      = 32,
  localparam int NUM_ID    = PRIV + NUM_SHARED,
  localparam int NUM_IN    = NUM_SHARED + NUM_CPU * PRIV,
  localparam int NUM_CELL  = NUM_ID * NUM_CPU,
  localparam int ID_WORDS  = NUM_ID / PRIV,
  localparam int WORD_W    = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqLines,
  input  logic              wrEn,
  input  logic [2:0]        wrOp,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [CPU_W-1:0]  wrCpu,
  input  logic [PRIV-1:0]   wrData,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] rdWord,
  output logic [PRIV-1:0]   rdData
);
  logic [NUM_CELL-1:0] cellIn;
  ctrlStrobeT          strobes;

  irqLineMap #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .PRIV(PRIV)) uMap (
    .irqLines(irqLines),
    .cellIn  (cellIn)
  );

  irqPendCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrOp   (wrOp),
    .rdEn   (rdEn),
    .strobes(strobes)
  );

  irqPendDatapath #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .PRIV(PRIV)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .cellIn (cellIn),
    .strobes(strobes),
    .wrWord (wrWord),
    .wrCpu  (wrCpu),
    .wrData (wrData),
    .rdWord (rdWord),
    .rdData (rdData)
  );
endmodule

// File: tb/irqPendTracker_test.sv
`timescale 1ns/1ps
module irqPendTracker_test;
  localparam int NCPU = 4;
  localparam int NSH  = 32;
  localparam int NID  = 32 + NSH;
  localparam int NIN  = NSH + NCPU * 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NIN-1:0]  irqLines = '0;
  logic            wrEn = 1'b0;
  logic [2:0]      wrOp = 3'd0;
  logic            wrWord = 1'b0;
  logic [1:0]      wrCpu = 2'd0;
  logic [31:0]     wrData = '0;
  logic            rdEn = 1'b0;
  logic            rdWord = 1'b0;
  logic [31:0]     rdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R11";

  bit mLvl[NID][NCPU];
  bit mLat[NID][NCPU];
  bit mEn[NID];
  bit mTrig[NID];
  logic [31:0] prevRd = '0;

  always #2.5 clk = ~clk;

  irqPendTracker uut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .wrEn(wrEn), .wrOp(wrOp),
    .wrWord(wrWord), .wrCpu(wrCpu), .wrData(wrData), .rdEn(rdEn),
    .rdWord(rdWord), .rdData(rdData)
  );

  function automatic bit wireOf(int id, int c);
    if (id < 32) return irqLines[NSH + c*32 + id];
    return irqLines[id - 32];
  endfunction

  function automatic logic [31:0] modelRead(int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int id = w*32 + b;
      for (int c = 0; c < NCPU; c++)
        if (mLat[id][c] || (mLvl[id][c] && !mTrig[id])) r[b] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic modelStep();
    bit nEn[NID];
    bit nTrig[NID];
    for (int id = 0; id < NID; id++) begin
      bit hit = wrEn && wrData[id%32] && (int'(wrWord) == id/32);
      nEn[id] = mEn[id];
      nTrig[id] = mTrig[id];
      if (hit && wrOp == 3'd1) nEn[id] = 1'b1;
      if (hit && wrOp == 3'd2) nEn[id] = 1'b0;
      if (wrEn && wrOp == 3'd5 && int'(wrWord) == id/32) nTrig[id] = wrData[id%32];
      for (int c = 0; c < NCPU; c++) begin
        bit tgt = hit && (id >= 32 || int'(wrCpu) == c);
        bit w = wireOf(id, c);
        bit nl = mLat[id][c];
        if (tgt && wrOp == 3'd4) nl = 1'b0;
        if (tgt && wrOp == 3'd3) nl = 1'b1;
        if (w && !mLvl[id][c] && (mTrig[id] || mEn[id])) nl = 1'b1;
        mLat[id][c] = nl;
        mLvl[id][c] = w;
      end
    end
    for (int id = 0; id < NID; id++) begin
      mEn[id] = nEn[id];
      mTrig[id] = nTrig[id];
    end
  endtask

  task automatic cycle();
    bit doRd = rdEn;
    logic [31:0] exp = doRd ? modelRead(int'(rdWord)) : prevRd;
    modelStep();
    @(posedge clk);
    #1;
    check(tag, rdData, exp);
    prevRd = rdData;
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rdEn = 1'b0;
    wrEn = 1'b0;
    @(posedge clk);
    #1;
    rstN = 1'b1;
    for (int id = 0; id < NID; id++) begin
      mEn[id] = 1'b0;
      mTrig[id] = 1'b0;
      for (int c = 0; c < NCPU; c++) begin
        mLvl[id][c] = 1'b0;
        mLat[id][c] = 1'b0;
      end
    end
    prevRd = '0;
  endtask

  task automatic wr(logic [2:0] op, bit w, logic [1:0] cpu, logic [31:0] d);
    wrEn = 1'b1; wrOp = op; wrWord = w; wrCpu = cpu; wrData = d;
    cycle();
  endtask

  task automatic rd(bit w);
    rdEn = 1'b1; rdWord = w;
    cycle();
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed = $urandom(32'h5A17);
    doReset();
    tag = "R11"; rd(1'b0); rd(1'b1); check("R11", rdData, 32'h0);

    // level-mode shared line 5 -> ID 37, disabled, still pending
    tag = "R4"; irqLines[5] = 1'b1; rd(1'b1); rd(1'b1);
    check("R4", rdData, 32'h0000_0020);
    tag = "R5"; irqLines[5] = 1'b0; rd(1'b1); rd(1'b1);
    check("R5", rdData, 32'h0);

    // shared edge-triggered while disabled -> ID 40 latched on all cpus
    tag = "R9"; wr(3'd5, 1'b1, 2'd0, 32'h0000_0F00);
    tag = "R1"; irqLines[8] = 1'b1; rd(1'b1); irqLines[8] = 1'b0; rd(1'b1); rd(1'b1);
    check("R1", rdData, 32'h0000_0100);
    tag = "R3"; wr(3'd4, 1'b1, 2'd2, 32'h0000_0100); rd(1'b1);
    check("R3", rdData, 32'h0);

    // private line: cpu 2, ID 7, edge mode
    tag = "R9"; wr(3'd5, 1'b0, 2'd0, 32'hFFFF_FFFF);
    tag = "R2"; irqLines[NSH + 2*32 + 7] = 1'b1; rd(1'b0); rd(1'b0);
    check("R2", rdData, 32'h0000_0080);
    tag = "R8"; wr(3'd4, 1'b0, 2'd1, 32'h0000_0080); rd(1'b0);
    check("R8", rdData, 32'h0000_0080);
    wr(3'd4, 1'b0, 2'd2, 32'h0000_0080); rd(1'b0);
    check("R8", rdData, 32'h0);
    irqLines[NSH + 2*32 + 7] = 1'b0; rd(1'b0);

    // level mode line held high survives clear-pending
    tag = "R8"; wr(3'd3, 1'b1, 2'd0, 32'h0000_0001); irqLines[0] = 1'b1; rd(1'b1);
    wr(3'd4, 1'b1, 2'd0, 32'h0000_0001); rd(1'b1);
    check("R8", rdData, 32'h0000_0001);
    irqLines[0] = 1'b0; rd(1'b1); rd(1'b1);
    check("R8", rdData, 32'h0);

    // set-pending with zero bits and enable path
    tag = "R7"; wr(3'd3, 1'b1, 2'd0, 32'h8000_0000); rd(1'b1);
    check("R7", rdData, 32'h8000_0000);
    tag = "R9"; wr(3'd1, 1'b1, 2'd0, 32'h0000_0004); wr(3'd6, 1'b1, 2'd0, 32'hFFFF_FFFF);
    tag = "R3"; irqLines[2] = 1'b1; rd(1'b1); irqLines[2] = 1'b0; rd(1'b1); rd(1'b1);
    check("R3", rdData, 32'h8000_0004);

    // simultaneous rise and clear, edge mode ID 41
    tag = "R12"; irqLines[9] = 1'b1;
    wrEn = 1'b1; wrOp = 3'd4; wrWord = 1'b1; wrData = 32'h0000_0200; rdEn = 1'b1; rdWord = 1'b1;
    cycle(); rd(1'b1);
    check("R12", rdData & 32'h0000_0200, 32'h0000_0200);

    // unchanged wires with no pending write
    tag = "R6"; rd(1'b1); rd(1'b1);
    // read hold
    tag = "R10"; rdEn = 1'b0; cycle(); check("R10", rdData, prevRd);

    // random mixture
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 1) == 1) begin
        int k = $urandom_range(0, NIN - 1);
        irqLines[k] = ~irqLines[k];
      end
      if ($urandom_range(0, 2) == 0) begin
        wrEn = 1'b1; wrOp = 3'($urandom_range(0, 5)); wrWord = 1'($urandom_range(0, 1));
        wrCpu = 2'($urandom_range(0, 3)); wrData = $urandom & $urandom;
      end
      rdEn = ($urandom_range(0, 7) != 0); rdWord = 1'($urandom_range(0, 1));
      cycle();
    end

    tag = "R11"; doReset(); rdEn = 1'b1; rdWord = 1'b1; irqLines = '0; cycle(); rd(1'b0);
    check("R11", rdData, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule